// File: doc/BRIEF.md
# PWM Fault Trip Controller

This block sits between a PWM generator and the gate drivers of a power stage. It watches an external, asynchronous fault pin and, once the pin reaches its active level, takes over every gate output and puts it into a safe state. No processor action is needed for this. The safe state is chosen by an input. It is either every gate driven low, or every gate released to high impedance by dropping its output enable.

The active level of the fault pin can be configured. The way the block recovers can also be configured. In automatic recovery, the gates are handed back to the PWM generator at the first period-boundary strobe that arrives once the fault has gone away. In manual recovery, the trip stays latched until a software clear strobe arrives while the fault is inactive. Reset leaves the block tripped, so the power stage stays safe until the first valid release condition.

Top module: `pwm_trip_guard`

## Requirements
- R1: While reset is applied and on the first cycle after it, tripped_o is 1 and every gate_o bit is 0.
- R2: With fault_active_low_i=0 a high level on fault_async_i is a fault. With fault_active_low_i=1 a low level on fault_async_i is a fault.
- R3: From the running state, if the fault pin is sampled active on a rising edge, tripped_o is 1 and the gates are safe no later than the third rising edge counted from that one (two synchronizer flops plus the state flop).
- R4: While tripped with safe_hiz_i=0, every gate_o bit is 0 and every gate_oe_o bit is 1.
- R5: While tripped with safe_hiz_i=1, every gate_oe_o bit is 0 and every gate_o bit is 0.
- R6: While running, gate_o equals gate_i and every gate_oe_o bit is 1.
- R7: With recover_auto_i=1, the block leaves the tripped state only on a clock edge where period_tick_i is 1 and the synchronized fault is inactive. A period tick during an active fault does not release it, and clear_i has no effect.
- R8: With recover_auto_i=0, the block leaves the tripped state only on a clock edge where clear_i is 1 and the synchronized fault is inactive. period_tick_i has no effect.
- R9: A clear_i strobe given while the fault is still active is ignored. The trip stays latched after the fault later goes inactive, until a new clear arrives.
- R10: tripped_o is 1 exactly while the gates are forced safe, and it is 0 while gate_i is passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_async_i | input | 1 | Asynchronous fault pin |
| fault_active_low_i | input | 1 | 1: fault pin is active low; 0: active high |
| recover_auto_i | input | 1 | 1: automatic recovery at period boundary; 0: manual clear |
| safe_hiz_i | input | 1 | 1: safe state is high impedance; 0: driven low |
| clear_i | input | 1 | Software clear strobe |
| period_tick_i | input | 1 | PWM period-boundary strobe |
| gate_i | input | NUM_GATES | Gate signals from the PWM generator |
| gate_o | output | NUM_GATES | Gate signals towards the drivers |
| gate_oe_o | output | NUM_GATES | Per-gate output enable (0 = high impedance) |
| tripped_o | output | 1 | Fault trip status |

## Verification
The hardest situation to reach from the ports is a manual clear that is ignored. The clear has to arrive while the synchronized fault is still active, and the latch then has to be seen to persist after the pin goes quiet. The bench issues the clear with the pin held active, releases the pin, and waits past the synchronizer depth. It then checks that the block is still tripped before it sends a second clear. A similar sequence checks that period ticks and clears are each ignored by the recovery mode that does not use them. In every case the pin is first held inactive for longer than the synchronizer delay, so the strobe is the only thing that can cause a release.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;

    typedef enum logic {
        TG_RUN     = 1'b0,
        TG_TRIPPED = 1'b1
    } trip_state_e;

    typedef struct packed {
        logic auto_recover;
        logic clear;
        logic period_tick;
    } release_req_t;

    function automatic logic fault_is_active(input logic level, input logic active_low);
        return level ^ active_low;
    endfunction

    function automatic logic release_ok(input release_req_t req, input logic fault);
        return !fault && (req.auto_recover ? req.period_tick : req.clear);
    endfunction

endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic active_low_i,
    output logic fault_o
);
    import pwm_trip_pkg::*;

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign fault_o = fault_is_active(chain[STAGES-1], active_low_i);

endmodule

// File: rtl/trip_fsm.sv
module trip_fsm (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fault_i,
    input  pwm_trip_pkg::release_req_t  req_i,
    output logic                        tripped_o
);
    import pwm_trip_pkg::*;

    trip_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            TG_RUN:     if (fault_i)                state_d = TG_TRIPPED;
            TG_TRIPPED: if (release_ok(req_i, fault_i)) state_d = TG_RUN;
            default:    state_d = TG_TRIPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TG_TRIPPED;
        else     state_q <= state_d;
    end

    assign tripped_o = (state_q == TG_TRIPPED);

    // R3
    trip_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!tripped_o && fault_i) |=> tripped_o);

    // R9
    hold_while_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (tripped_o && fault_i) |=> tripped_o);

    // R7
    auto_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tripped_o && req_i.auto_recover && !req_i.period_tick) |=> tripped_o);

    // R8
    manual_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tripped_o && !req_i.auto_recover && !req_i.clear) |=> tripped_o);

endmodule

// File: rtl/trip_gate_mux.sv
module trip_gate_mux #(
    parameter int NUM_GATES = 4
) (
    input  logic                 tripped_i,
    input  logic                 safe_hiz_i,
    input  logic [NUM_GATES-1:0] gate_i,
    output logic [NUM_GATES-1:0] gate_o,
    output logic [NUM_GATES-1:0] gate_oe_o
);
    generate
        for (genvar g = 0; g < NUM_GATES; g++) begin : g_lane
            assign gate_o[g]    = tripped_i ? 1'b0 : gate_i[g];
            assign gate_oe_o[g] = tripped_i ? !safe_hiz_i : 1'b1;
        end
    endgenerate

endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard #(
    parameter int NUM_GATES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fault_async_i,
    input  logic                 fault_active_low_i,
    input  logic                 recover_auto_i,
    input  logic                 safe_hiz_i,
    input  logic                 clear_i,
    input  logic                 period_tick_i,
    input  logic [NUM_GATES-1:0] gate_i,
    output logic [NUM_GATES-1:0] gate_o,
    output logic [NUM_GATES-1:0] gate_oe_o,
    output logic                 tripped_o
);
    import pwm_trip_pkg::*;

    logic         fault_sync;
    release_req_t req;

    assign req.auto_recover = recover_auto_i;
    assign req.clear        = clear_i;
    assign req.period_tick  = period_tick_i;

    trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .pin_i        (fault_async_i),
        .active_low_i (fault_active_low_i),
        .fault_o      (fault_sync)
    );

    trip_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .fault_i   (fault_sync),
        .req_i     (req),
        .tripped_o (tripped_o)
    );

    trip_gate_mux #(.NUM_GATES(NUM_GATES)) u_mux (
        .tripped_i  (tripped_o),
        .safe_hiz_i (safe_hiz_i),
        .gate_i     (gate_i),
        .gate_o     (gate_o),
        .gate_oe_o  (gate_oe_o)
    );

    // R1
    reset_trip_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> tripped_o);

    // R4
    safe_low_chk: assert property (@(posedge clk) disable iff (rst)
        (tripped_o && !safe_hiz_i) |-> (gate_o == '0 && gate_oe_o == '1));

    // R5
    safe_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (tripped_o && safe_hiz_i) |-> (gate_oe_o == '0 && gate_o == '0));

    // R6
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        !tripped_o |-> (gate_o == gate_i && gate_oe_o == '1));

endmodule

// File: tb/pwm_trip_guard_tb.sv
module pwm_trip_guard_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         fault_async_i;
    logic         fault_active_low_i;
    logic         recover_auto_i;
    logic         safe_hiz_i;
    logic         clear_i;
    logic         period_tick_i;
    logic [N-1:0] gate_i;
    logic [N-1:0] gate_o;
    logic [N-1:0] gate_oe_o;
    logic         tripped_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pwm_trip_guard #(.NUM_GATES(N), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .fault_async_i(fault_async_i),
        .fault_active_low_i(fault_active_low_i), .recover_auto_i(recover_auto_i),
        .safe_hiz_i(safe_hiz_i), .clear_i(clear_i), .period_tick_i(period_tick_i),
        .gate_i(gate_i), .gate_o(gate_o), .gate_oe_o(gate_oe_o), .tripped_o(tripped_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive the pin to the active (1) or inactive (0) fault level
    task automatic set_fault(input bit act);
        fault_async_i = act ^ fault_active_low_i;
    endtask

    task automatic pulse_tick();
        period_tick_i = 1'b1; cyc(1); period_tick_i = 1'b0;
    endtask

    task automatic pulse_clear();
        clear_i = 1'b1; cyc(1); clear_i = 1'b0;
    endtask

    task automatic expect_run(input string req);
        chk({req, " tripped"}, tripped_o, 1'b0);
        chk({req, " gate_o"}, gate_o, gate_i);
        chk({req, " oe"}, gate_oe_o, {N{1'b1}});
    endtask

    task automatic release_auto();
        set_fault(0); cyc(3); pulse_tick();
    endtask

    task automatic t_reset();
        rst = 1'b1; fault_active_low_i = 0; recover_auto_i = 1; safe_hiz_i = 0;
        clear_i = 0; period_tick_i = 0; gate_i = 4'b1010; fault_async_i = 0;
        cyc(3);
        chk("R1 tripped in reset", tripped_o, 1'b1);
        chk("R1 gate_o in reset", gate_o, '0);
        rst = 1'b0; cyc(1);
        chk("R1 tripped after reset", tripped_o, 1'b1);
        chk("R4 oe after reset", gate_oe_o, {N{1'b1}});
    endtask

    task automatic t_run_and_trip();
        release_auto();
        expect_run("R6 released");
        gate_i = 4'b0110; cyc(1);
        chk("R6 pass pattern", gate_o, 4'b0110);
        set_fault(1); cyc(3);
        chk("R3 trip within three edges", tripped_o, 1'b1);
        chk("R4 gate low", gate_o, '0);
        chk("R4 oe driven", gate_oe_o, {N{1'b1}});
        chk("R10 tripped flag with safe gates", tripped_o, 1'b1);
    endtask

    task automatic t_hiz();
        safe_hiz_i = 1'b1; cyc(1);
        chk("R5 oe released", gate_oe_o, '0);
        chk("R5 gate low", gate_o, '0);
        safe_hiz_i = 1'b0; cyc(1);
        chk("R4 oe back on", gate_oe_o, {N{1'b1}});
    endtask

    task automatic t_auto_recover();
        pulse_tick(); cyc(1);
        chk("R7 tick during fault ignored", tripped_o, 1'b1);
        set_fault(0); cyc(3);
        chk("R7 no release without tick", tripped_o, 1'b1);
        pulse_clear(); cyc(1);
        chk("R7 clear ignored in auto", tripped_o, 1'b1);
        pulse_tick();
        expect_run("R7 released at tick");
        chk("R10 flag clear when released", tripped_o, 1'b0);
    endtask

    task automatic t_polarity();
        set_fault(1); cyc(3);
        chk("R2 active-high trip", tripped_o, 1'b1);
        fault_async_i = 1'b1; fault_active_low_i = 1'b1; cyc(3);
        pulse_tick();
        expect_run("R2 high pin inactive when active-low");
        fault_async_i = 1'b0; cyc(3);
        chk("R2 active-low trip", tripped_o, 1'b1);
        release_auto();
        expect_run("R2 release with active-low");
        fault_active_low_i = 1'b1;
    endtask

    task automatic t_manual_recover();
        recover_auto_i = 1'b0;
        set_fault(1); cyc(3);
        chk("R8 tripped", tripped_o, 1'b1);
        set_fault(0); cyc(3);
        pulse_tick(); cyc(1);
        chk("R8 tick ignored in manual", tripped_o, 1'b1);
        pulse_clear();
        expect_run("R8 released by clear");
    endtask

    task automatic t_manual_clear_ignored();
        set_fault(1); cyc(3);
        pulse_clear(); cyc(1);
        chk("R9 clear during fault ignored", tripped_o, 1'b1);
        set_fault(0); cyc(4);
        chk("R9 still latched", tripped_o, 1'b1);
        chk("R9 gates still safe", gate_o, '0);
        pulse_clear();
        expect_run("R9 second clear releases");
    endtask

    initial begin
        t_reset();
        t_run_and_trip();
        t_hiz();
        t_auto_recover();
        t_polarity();
        t_manual_recover();
        t_manual_clear_ignored();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule